// File: doc/BRIEF.md
# Store drain queue

This block is a circular queue for stores that have already executed. Each store stays in the queue until the pipeline commits it. Committed stores then drain to the data cache in program order through a writeback pointer that runs between the head and the tail. A store is retired from the head only once it is done. Completion responses can come back in any order, so the head advances over the longest contiguous run of done entries that starts at the head.

The pipeline drives three commands:
- **Allocate** places a store at the tail and returns its queue index.
- **Commit** carries the youngest committed sequence number. Every older store that is not yet flagged gets a write-allowed flag.
- **Squash** removes the youngest stores that are newer than a given sequence number. It never removes a store that carries the write-allowed flag.

Toward the cache the block drives a write request with a valid/ready handshake, tagged with the queue index. A rejected request goes into a one-entry retry slot, and the store path stays blocked until a retry pulse arrives. The block also combines its own free count with the load queue's free count into a single free-entry figure for dispatch.

Top module: `store_drain_queue`

## Requirements
- R1: After reset the following all hold. The queue is empty and the count is 0. The allocation index is 0. No write is requested. The path is not blocked. The pending-writeback count is 0.
- R2: An allocate is accepted when the queue holds fewer than DEPTH stores and no squash is present in the same cycle. The store is written at index `alloc_idx`, and `alloc_idx` then steps by one modulo DEPTH+1. When DEPTH stores are held, `full` is 1 and an allocate changes neither `count` nor `alloc_idx`.
- R3: A commit walks from the head and flags each unflagged store whose sequence number is at or below `commit_seq`. It stops at the first unflagged store that is younger. `pending_wb` grows by the number of newly flagged stores.
- R4: A write request is presented only when all of the following hold: `pending_wb` is nonzero, the entry at the writeback pointer is flagged, `cache_busy` is 0, and the path is not blocked. Requests are issued oldest first, at most one per cycle. Each request carries the stored address, data and size, with `wr_tag` equal to the queue index.
- R5: A flagged store of size 0 completes without any request. In the same cycle the writeback pointer advances, the store is marked done, and `pending_wb` drops by one. `cache_busy` holds this step back as well.
- R6: A request presented with `wr_ready` low sets `wr_blocked`. While `wr_blocked` is 1, no request appears until the cycle after a `retry_in` pulse. In that cycle the held request is presented again. If it is accepted, `wr_blocked` clears. If it is rejected, the path stays blocked.
- R7: A response on `resp_tag` marks that store done and lowers `pending_wb` by one. The head advances only over done stores that are contiguous from the head. A younger store that completes first frees nothing.
- R8: A squash removes the youngest stores whose sequence number is greater than `squash_seq`. It stops at the first store that is older or flagged. An allocate in the same cycle is ignored.
- R9: When commit and squash occur in the same cycle, the commit is applied first. A store that the commit flags survives the squash even if its number is greater than `squash_seq`.
- R10: `free_entries` equals min(`lq_free`, DEPTH+1-`count`) - 1, where `lq_free` is the load queue's raw free-slot count including its sentinel. The result floors at 0.
- R11: A `retry_in` pulse while the path is not blocked has no effect. No request appears, and `wr_blocked` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | 8*DATA_BYTES | Store data bytes |
| alloc_size | input | clog2(DATA_BYTES+1) | Byte count, 0 means no write |
| alloc_idx | output | clog2(DEPTH+1) | Index the next store receives (tail) |
| full | output | 1 | DEPTH stores held |
| empty | output | 1 | No store held |
| count | output | clog2(DEPTH+2) | Stores held |
| commit_valid | input | 1 | Commit command |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash command |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| lq_free | input | clog2(DEPTH+2) | Load queue raw free slots incl. sentinel |
| free_entries | output | clog2(DEPTH+2) | Combined free entries for dispatch |
| pending_wb | output | clog2(DEPTH+2) | Flagged stores not yet completed |
| cache_busy | input | 1 | Cache cannot take new stores this cycle |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Cache accepts the request this cycle |
| wr_addr | output | ADDR_W | Request address |
| wr_data | output | 8*DATA_BYTES | Request data |
| wr_size | output | clog2(DATA_BYTES+1) | Request byte count |
| wr_tag | output | clog2(DEPTH+1) | Queue index of the request |
| wr_blocked | output | 1 | Store path waiting for retry |
| retry_in | input | 1 | Cache retry pulse |
| resp_valid | input | 1 | Write completion response |
| resp_tag | input | clog2(DEPTH+1) | Queue index being completed |

## Verification
Commit and squash can land in the same cycle, and the bench provokes this on purpose. It commits sequence 12 while squashing everything above 11, with two uncommitted stores (12 and 13) in the queue. If squash were applied before commit, both stores would disappear. The bench therefore judges the outcome by three results: the count left at one, the allocation index rolled back by one slot, and a write request tagged with the surviving store's index. A stray allocate is driven in that same cycle, and the bench confirms it was dropped.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // index k slots past p on a ring of the given size
  function automatic int unsigned ring_step(int unsigned p, int unsigned k, int unsigned slots);
    return (p + k) % slots;
  endfunction

  // slots between from (inclusive) and to (exclusive) on the ring
  function automatic int unsigned ring_span(int unsigned from, int unsigned to, int unsigned slots);
    return (to + slots - from) % slots;
  endfunction

  function automatic int unsigned min_u(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int SEQ_W = 16,
  parameter int PW    = 3,
  parameter int CW    = 3
) (
  input  logic [PW-1:0]             head,
  input  logic [CW-1:0]             occ,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
  input  logic [SLOTS-1:0]          wa,
  input  logic                      commit_valid,
  input  logic [SEQ_W-1:0]          commit_seq,
  output logic [SLOTS-1:0]          wa_nx,
  output logic [CW-1:0]             newly
);

  logic          halt;
  logic [PW-1:0] ix;

  // oldest-first walk; flagged entries are skipped, the first younger
  // unflagged entry ends the walk
  always_comb begin
    wa_nx = wa;
    newly = '0;
    halt  = !commit_valid;
    ix    = '0;
    for (int k = 0; k < SLOTS; k++) begin
      ix = PW'(ring_step(32'(head), k, SLOTS));
      if (!halt && (k < int'(occ)) && !wa[ix]) begin
        if (seq[ix] <= commit_seq) begin
          wa_nx[ix] = 1'b1;
          newly     = newly + CW'(1);
        end else begin
          halt = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int SEQ_W = 16,
  parameter int PW    = 3,
  parameter int CW    = 3
) (
  input  logic [PW-1:0]             head,
  input  logic [CW-1:0]             occ,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
  input  logic [SLOTS-1:0]          wa,
  input  logic                      squash_valid,
  input  logic [SEQ_W-1:0]          squash_seq,
  output logic [CW-1:0]             keep
);

  logic          halt;
  logic [PW-1:0] ix;

  // newest-first walk; a flagged or old-enough entry ends it
  always_comb begin
    keep = occ;
    halt = !squash_valid;
    ix   = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      ix = PW'(ring_step(32'(head), k, SLOTS));
      if (!halt && (k < int'(occ))) begin
        if (wa[ix] || (seq[ix] <= squash_seq)) halt = 1'b1;
        else keep = CW'(k);
      end
    end
  end

endmodule

// File: rtl/sq_head_run.sv
module sq_head_run
  import sq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int PW    = 3,
  parameter int CW    = 3
) (
  input  logic [PW-1:0]    head,
  input  logic [CW-1:0]    occ,
  input  logic [SLOTS-1:0] done,
  output logic [CW-1:0]    adv
);

  logic          halt;
  logic [PW-1:0] ix;

  // length of the done run starting at the head, bounded by occupancy
  always_comb begin
    adv  = '0;
    halt = 1'b0;
    ix   = '0;
    for (int k = 0; k < SLOTS; k++) begin
      ix = PW'(ring_step(32'(head), k, SLOTS));
      if (!halt && (k < int'(occ))) begin
        if (done[ix]) adv = adv + CW'(1);
        else halt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sq_wb_engine.sv
module sq_wb_engine
  import sq_pkg::*;
#(
  parameter int SLOTS  = 5,
  parameter int PW     = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     tail,
  input  logic              pend_nz,
  input  logic              ent_wa,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [DATA_W-1:0] ent_data,
  input  logic [SIZE_W-1:0] ent_size,
  input  logic              cache_busy,
  input  logic              wr_ready,
  input  logic              retry_in,
  output logic [PW-1:0]     wb_ptr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [SIZE_W-1:0] wr_size,
  output logic [PW-1:0]     wr_tag,
  output logic              blocked,
  output logic              zero_done
);

  logic              armed;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_data;
  logic [SIZE_W-1:0] slot_size;
  logic [PW-1:0]     slot_tag;
  logic              fresh_ok, fresh_wr, resend, accepted;

  assign fresh_ok  = !blocked && pend_nz && (wb_ptr != tail) && ent_wa && !cache_busy;
  assign zero_done = fresh_ok && (ent_size == '0);
  assign fresh_wr  = fresh_ok && (ent_size != '0);
  assign resend    = blocked && armed;
  assign wr_valid  = fresh_wr || resend;
  assign accepted  = wr_valid && wr_ready;

  assign wr_addr = resend ? slot_addr : ent_addr;
  assign wr_data = resend ? slot_data : ent_data;
  assign wr_size = resend ? slot_size : ent_size;
  assign wr_tag  = resend ? slot_tag  : wb_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ptr    <= '0;
      blocked   <= 1'b0;
      armed     <= 1'b0;
      slot_addr <= '0;
      slot_data <= '0;
      slot_size <= '0;
      slot_tag  <= '0;
    end else begin
      if (zero_done || accepted) wb_ptr <= PW'(ring_step(32'(wb_ptr), 1, SLOTS));
      if (fresh_wr && !wr_ready) begin
        blocked   <= 1'b1;
        slot_addr <= ent_addr;
        slot_data <= ent_data;
        slot_size <= ent_size;
        slot_tag  <= wb_ptr;
      end else if (resend && wr_ready) begin
        blocked <= 1'b0;
      end
      armed <= blocked && !resend && (armed || retry_in);
    end
  end

  p_reject_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> blocked);

  p_quiet_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !$past(retry_in) && !armed) |-> !wr_valid);

  p_issue_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !blocked) |-> pend_nz);

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ptr == $past(wb_ptr)) || (wb_ptr == PW'(ring_step(32'($past(wb_ptr)), 1, SLOTS))));

endmodule

// File: rtl/store_drain_queue.sv
module store_drain_queue
  import sq_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  localparam int SLOTS  = DEPTH + 1,
  localparam int PW     = $clog2(SLOTS),
  localparam int CW     = $clog2(SLOTS + 1),
  localparam int DATA_W = 8 * DATA_BYTES,
  localparam int SIZE_W = $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic [SIZE_W-1:0] alloc_size,
  output logic [PW-1:0]     alloc_idx,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic [CW-1:0]     lq_free,
  output logic [CW-1:0]     free_entries,
  output logic [CW-1:0]     pending_wb,
  input  logic              cache_busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [SIZE_W-1:0] wr_size,
  output logic [PW-1:0]     wr_tag,
  output logic              wr_blocked,
  input  logic              retry_in,
  input  logic              resp_valid,
  input  logic [PW-1:0]     resp_tag
);

  // ring state
  logic [PW-1:0] head, tail, wb_ptr;
  logic [CW-1:0] occ, pending;
  logic [SLOTS-1:0] wa, done;
  logic [SLOTS-1:0][SEQ_W-1:0]  e_seq;
  logic [SLOTS-1:0][ADDR_W-1:0] e_addr;
  logic [SLOTS-1:0][DATA_W-1:0] e_data;
  logic [SLOTS-1:0][SIZE_W-1:0] e_size;

  // named internal events
  logic             alloc_fire;
  logic             zero_done;
  logic [SLOTS-1:0] wa_nx, done_nx;
  logic [CW-1:0]    newly, keep, adv, wb_dist;
  logic [PW-1:0]    head_nx, tail_nx;
  logic [CW-1:0]    pending_nx;
  int unsigned      free_lim;

  assign occ        = CW'(ring_span(32'(head), 32'(tail), SLOTS));
  assign wb_dist    = CW'(ring_span(32'(head), 32'(wb_ptr), SLOTS));
  assign full       = (int'(occ) == DEPTH);
  assign empty      = (occ == '0);
  assign count      = occ;
  assign alloc_idx  = tail;
  assign pending_wb = pending;
  assign alloc_fire = alloc_valid && !full && !squash_valid;

  assign free_lim     = min_u(32'(lq_free), SLOTS - 32'(occ));
  assign free_entries = (free_lim == 0) ? '0 : CW'(free_lim - 1);

  sq_commit_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .PW(PW), .CW(CW)) u_commit (
    .head(head), .occ(occ), .seq(e_seq), .wa(wa),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .wa_nx(wa_nx), .newly(newly)
  );

  // squash sees the flags the same-cycle commit sets
  sq_squash_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .PW(PW), .CW(CW)) u_squash (
    .head(head), .occ(occ), .seq(e_seq), .wa(wa_nx),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .keep(keep)
  );

  sq_wb_engine #(.SLOTS(SLOTS), .PW(PW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .tail(tail), .pend_nz(pending != '0),
    .ent_wa(wa[wb_ptr]), .ent_addr(e_addr[wb_ptr]), .ent_data(e_data[wb_ptr]),
    .ent_size(e_size[wb_ptr]), .cache_busy(cache_busy), .wr_ready(wr_ready),
    .retry_in(retry_in), .wb_ptr(wb_ptr), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size(wr_size), .wr_tag(wr_tag), .blocked(wr_blocked),
    .zero_done(zero_done)
  );

  always_comb begin
    done_nx = done;
    if (resp_valid) done_nx[resp_tag] = 1'b1;
    if (zero_done)  done_nx[wb_ptr]   = 1'b1;
  end

  sq_head_run #(.SLOTS(SLOTS), .PW(PW), .CW(CW)) u_head (
    .head(head), .occ(occ), .done(done_nx), .adv(adv)
  );

  assign head_nx    = PW'(ring_step(32'(head), 32'(adv), SLOTS));
  assign pending_nx = pending + newly - CW'(resp_valid) - CW'(zero_done);

  always_comb begin
    if (squash_valid)    tail_nx = PW'(ring_step(32'(head), 32'(keep), SLOTS));
    else if (alloc_fire) tail_nx = PW'(ring_step(32'(tail), 1, SLOTS));
    else                 tail_nx = tail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      pending <= '0;
      wa      <= '0;
      done    <= '0;
    end else begin
      head    <= head_nx;
      tail    <= tail_nx;
      pending <= pending_nx;
      wa      <= wa_nx;
      done    <= done_nx;
      if (alloc_fire) begin
        wa[tail]   <= 1'b0;
        done[tail] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      e_seq[tail]  <= alloc_seq;
      e_addr[tail] <= alloc_addr;
      e_data[tail] <= alloc_data;
      e_size[tail] <= alloc_size;
    end
  end

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  p_full_holds_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid && !squash_valid) |=> (alloc_idx == $past(alloc_idx)));

  p_pending_le_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= occ);

  p_head_behind_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_dist <= occ);

  p_squash_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (count <= $past(count)));

  p_free_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_entries) <= DEPTH);

endmodule

// File: tb/store_drain_queue_bench.sv
`timescale 1ns/1ps
module store_drain_queue_bench;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid;
  logic [15:0] alloc_seq;
  logic [31:0] alloc_addr;
  logic [63:0] alloc_data;
  logic [3:0]  alloc_size;
  logic [2:0]  alloc_idx;
  logic        full, empty;
  logic [2:0]  count;
  logic        commit_valid;
  logic [15:0] commit_seq;
  logic        squash_valid;
  logic [15:0] squash_seq;
  logic [2:0]  lq_free, free_entries, pending_wb;
  logic        cache_busy, wr_valid, wr_ready;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [3:0]  wr_size;
  logic [2:0]  wr_tag;
  logic        wr_blocked, retry_in, resp_valid;
  logic [2:0]  resp_tag;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  store_drain_queue #(.DEPTH(DEPTH)) u_store_drain_queue (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_addr(alloc_addr), .alloc_data(alloc_data), .alloc_size(alloc_size),
    .alloc_idx(alloc_idx), .full(full), .empty(empty), .count(count),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .lq_free(lq_free), .free_entries(free_entries), .pending_wb(pending_wb),
    .cache_busy(cache_busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size), .wr_tag(wr_tag),
    .wr_blocked(wr_blocked), .retry_in(retry_in), .resp_valid(resp_valid),
    .resp_tag(resp_tag)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] pat(input int i);
    return {32'hA5A5_0000 + 32'(i), 32'h0000_1000 + 32'(i)};
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic put(input int sq, input int ad, input logic [63:0] dt, input int sz);
    alloc_valid = 1'b1;
    alloc_seq   = 16'(sq);
    alloc_addr  = 32'(ad);
    alloc_data  = dt;
    alloc_size  = 4'(sz);
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic respond(input int tag);
    resp_valid = 1'b1;
    resp_tag   = 3'(tag);
    tick();
    resp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc_valid = 0; alloc_seq = 0; alloc_addr = 0; alloc_data = 0;
    alloc_size = 0; commit_valid = 0; commit_seq = 0; squash_valid = 0; squash_seq = 0;
    lq_free = 3'd5; cache_busy = 0; wr_ready = 1; retry_in = 0; resp_valid = 0; resp_tag = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 blocked", wr_blocked, 0);
    chk("R1 pending", pending_wb, 0);
    chk("R10 free at reset", free_entries, 4);

    // R2 fill past capacity, R10 free count tracks occupancy
    lq_free = 3'd3;
    for (int i = 0; i < 5; i++) begin
      put(10 + i, 'h100 + 8 * i, pat(i), 4);
      chk("R2 count", count, 64'(min2(i + 1, DEPTH)));
      chk("R2 alloc_idx", alloc_idx, 64'(min2(i + 1, DEPTH)));
      chk("R10 free", free_entries, 64'(min2(3, DEPTH + 1 - min2(i + 1, DEPTH)) - 1));
    end
    chk("R2 full", full, 1);
    chk("R4 no write before commit", wr_valid, 0);

    // R3 commit up to 11 flags two stores only
    commit_valid = 1; commit_seq = 16'd11;
    tick();
    commit_valid = 0;
    chk("R3 pending", pending_wb, 2);
    chk("R4 first valid", wr_valid, 1);
    chk("R4 first tag", wr_tag, 0);
    chk("R4 first addr", wr_addr, 'h100);
    chk("R4 first data", wr_data, pat(0));
    chk("R4 first size", wr_size, 4);
    tick();
    chk("R4 second valid", wr_valid, 1);
    chk("R4 second tag", wr_tag, 1);
    chk("R4 second addr", wr_addr, 'h108);
    tick();
    chk("R3 stop at younger", wr_valid, 0);
    chk("R3 pending held", pending_wb, 2);

    // R7 out-of-order completion
    respond(1);
    chk("R7 younger done frees nothing", count, 4);
    chk("R7 pending after first resp", pending_wb, 1);
    respond(0);
    chk("R7 head run frees two", count, 2);
    chk("R7 pending zero", pending_wb, 0);

    // R11 retry while unblocked
    retry_in = 1;
    tick();
    retry_in = 0;
    chk("R11 no request", wr_valid, 0);
    chk("R11 not blocked", wr_blocked, 0);

    // R9 commit 12 and squash above 11 in one cycle; R8 alloc ignored
    wr_ready = 0;
    commit_valid = 1; commit_seq = 16'd12;
    squash_valid = 1; squash_seq = 16'd11;
    alloc_valid = 1; alloc_seq = 16'd99; alloc_size = 4'd1;
    tick();
    commit_valid = 0; squash_valid = 0; alloc_valid = 0;
    chk("R9 survivor count", count, 1);
    chk("R8 tail rolled back, alloc dropped", alloc_idx, 3);
    chk("R9 pending", pending_wb, 1);
    chk("R9 survivor written", wr_valid, 1);
    chk("R9 survivor tag", wr_tag, 2);

    // R6 reject, wait, retry, reject again, retry, accept
    tick();
    chk("R6 blocked after reject", wr_blocked, 1);
    chk("R6 quiet after reject", wr_valid, 0);
    wr_ready = 1;
    tick();
    tick();
    chk("R6 quiet without retry", wr_valid, 0);
    retry_in = 1;
    tick();
    retry_in = 0;
    chk("R6 resend valid", wr_valid, 1);
    chk("R6 resend tag", wr_tag, 2);
    chk("R6 resend data", wr_data, pat(2));
    wr_ready = 0;
    tick();
    chk("R6 still blocked", wr_blocked, 1);
    chk("R6 quiet again", wr_valid, 0);
    retry_in = 1;
    tick();
    retry_in = 0;
    wr_ready = 1;
    chk("R6 second resend", wr_valid, 1);
    tick();
    chk("R6 unblocked", wr_blocked, 0);
    respond(2);
    chk("R7 drained", empty, 1);

    // R5 zero-size store, cache busy, ring wrap
    put(20, 'h200, pat(7), 0);
    put(21, 'h208, pat(8), 2);
    chk("R2 wrap alloc_idx", alloc_idx, 0);
    commit_valid = 1; commit_seq = 16'd21;
    tick();
    commit_valid = 0;
    cache_busy = 1;
    chk("R4 busy holds write", wr_valid, 0);
    tick();
    chk("R5 busy holds zero-size", pending_wb, 2);
    cache_busy = 0;
    chk("R5 no request for zero size", wr_valid, 0);
    tick();
    chk("R5 pending after zero size", pending_wb, 1);
    chk("R5 head passes zero size", count, 1);
    chk("R4 next tag", wr_tag, 4);
    chk("R4 next size", wr_size, 2);
    tick();
    respond(4);
    chk("R7 empty at end", count, 0);

    // R10 sweep of load-queue free slots on an empty queue
    for (int lq = 1; lq <= 5; lq++) begin
      lq_free = 3'(lq);
      #1;
      chk("R10 sweep", free_entries, 64'(lq - 1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule